// File: doc/BRIEF.md
# Line RDI Defect Persistence Detector

This block decides whether the far end is signalling a line-level remote defect. Once per received STS-3c frame, upstream framing logic presents the K2 overhead byte together with a one-cycle frame strobe. The block tests the low three bits of that byte for the remote-defect code. It declares the defect only after the code has been seen in five frames in a row. It withdraws the defect only after the code has been absent from five frames in a row.

The defect state drives a level that asks the downstream cell processor to declare loss of cell delineation. The block also emits a one-cycle pulse each time the state flips, which external interrupt logic can use. A small read port returns a status byte. Its top bit is the defect state, and its lower seven bits are defect flags that other detectors supply.

Top module: `rdil_detector`

## Requirements
- R1: A synchronous active-high reset clears the defect state, the change pulse and both frame-run counts. After reset, five fresh matching frames are needed before a declaration.
- R2: A frame matches when K2 bits [2:0] equal 3'b110, with bit 0 as the LSB. K2 bits [7:3] have no effect.
- R3: With the defect clear, the strobe that completes the fifth consecutive matching frame sets the defect. The new state is visible in the cycle after that strobe.
- R4: A non-matching frame restarts the matching-frame run from zero. Frames count as consecutive whatever the number of idle cycles between their strobes.
- R5: With the defect set, the strobe that completes the fifth consecutive non-matching frame clears the defect. A matching frame restarts that run.
- R6: While the frame strobe is low, K2 changes have no effect on the state or on either run.
- R7: The cell-delineation-loss request output equals the defect state in every cycle.
- R8: The change output pulses high for exactly the one cycle in which the new defect state first appears, and stays low otherwise.
- R9: With read enable high and the read address equal to 0x1107, the read data is {defect, flags[6:0]}. Flag bits from 6 down to 0 are: S1 unstable, K1/K2 unstable, SF, SD, LOF, SEF, LOS.
- R10: With read enable low, or with any other address, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameStb | input | 1 | One-cycle strobe marking a received frame with a valid K2 byte |
| k2Byte | input | 8 | K2 overhead byte of the current frame |
| otherFlags | input | 7 | Other overhead defect flags (S1 unstable down to LOS) |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 16 | Read address |
| rdData | output | 8 | Status byte, or zero when not selected |
| rdiDefect | output | 1 | Line remote defect declared |
| lcdReq | output | 1 | Loss-of-cell-delineation request to the cell processor |
| rdiChange | output | 1 | One-cycle pulse on every defect state change |

## Verification
Several properties are checked on every cycle. Each state change must coincide with a change pulse, and each change pulse must coincide with a real change. A declaration can only follow a strobed matching frame, and a clearance can only follow a strobed non-matching frame. The state stays still while no frame strobe arrives, and neither run count can exceed five. The count of exactly five is exercised only by the bench scenarios: runs broken on the fourth frame, strobes spaced by idle gaps, and a reset in the middle of a run. The bench also covers the K2 bits that do not take part in the match, and the decoding of the read address.

// File: rtl/rdil_pkg.sv
package rdil_pkg;

  // Strobes issued by the control to the datapath once per cycle
  typedef struct packed {
    logic bumpHit;    // advance the matching-frame run
    logic flushHit;   // restart the matching-frame run
    logic bumpMiss;   // advance the non-matching-frame run
    logic flushMiss;  // restart the non-matching-frame run
    logic raise;      // declare the defect
    logic drop;       // clear the defect
  } rdilStrobe_t;

  localparam int K2_W = 8;

endpackage

// File: rtl/rdil_ctrl.sv
module rdil_ctrl
  import rdil_pkg::*;
#(
  parameter int RUN_LEN = 5,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             frameStb,
  input  logic             k2Match,
  input  logic             defectQ,
  input  logic [CNT_W-1:0] hitCnt,
  input  logic [CNT_W-1:0] missCnt,
  output rdilStrobe_t      stb
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic hitFrame;
  logic missFrame;

  assign hitFrame  = frameStb & k2Match;
  assign missFrame = frameStb & ~k2Match;

  always_comb begin
    stb           = '0;
    stb.bumpHit   = hitFrame && (hitCnt != FULL);
    stb.flushHit  = missFrame;
    stb.bumpMiss  = missFrame && (missCnt != FULL);
    stb.flushMiss = hitFrame;
    stb.raise     = hitFrame && !defectQ && (hitCnt == LAST);
    stb.drop      = missFrame && defectQ && (missCnt == LAST);
  end

endmodule

// File: rtl/rdil_datapath.sv
module rdil_datapath
  import rdil_pkg::*;
#(
  parameter int                RUN_LEN     = 5,
  parameter int                CNT_W       = $clog2(RUN_LEN + 1),
  parameter int                CODE_W      = 3,
  parameter logic [CODE_W-1:0] DEFECT_CODE = 3'b110,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h1107,
  parameter int                FLAG_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  rdilStrobe_t       stb,
  input  logic [K2_W-1:0]   k2Byte,
  input  logic [FLAG_W-1:0] otherFlags,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              k2Match,
  output logic [CNT_W-1:0]  hitCnt,
  output logic [CNT_W-1:0]  missCnt,
  output logic              defectQ,
  output logic              changeQ,
  output logic [FLAG_W:0]   rdData
);

  assign k2Match = (k2Byte[CODE_W-1:0] == DEFECT_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hitCnt  <= '0;
      missCnt <= '0;
      defectQ <= 1'b0;
      changeQ <= 1'b0;
    end else begin
      if (stb.flushHit)      hitCnt <= '0;
      else if (stb.bumpHit)  hitCnt <= hitCnt + 1'b1;

      if (stb.flushMiss)     missCnt <= '0;
      else if (stb.bumpMiss) missCnt <= missCnt + 1'b1;

      if (stb.raise)         defectQ <= 1'b1;
      else if (stb.drop)     defectQ <= 1'b0;

      changeQ <= stb.raise | stb.drop;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn && (rdAddr == STATUS_ADDR)) rdData = {defectQ, otherFlags};
  end

endmodule

// File: rtl/rdil_detector.sv
module rdil_detector
  import rdil_pkg::*;
#(
  parameter int                RUN_LEN     = 5,
  parameter int                CODE_W      = 3,
  parameter logic [CODE_W-1:0] DEFECT_CODE = 3'b110,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h1107,
  parameter int                FLAG_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStb,
  input  logic [7:0]        k2Byte,
  input  logic [FLAG_W-1:0] otherFlags,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [FLAG_W:0]   rdData,
  output logic              rdiDefect,
  output logic              lcdReq,
  output logic              rdiChange
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);

  rdilStrobe_t      stb;
  logic             k2Match;
  logic [CNT_W-1:0] hitCnt;
  logic [CNT_W-1:0] missCnt;
  logic             defectQ;
  logic             changeQ;

  rdil_ctrl #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .frameStb (frameStb),
    .k2Match  (k2Match),
    .defectQ  (defectQ),
    .hitCnt   (hitCnt),
    .missCnt  (missCnt),
    .stb      (stb)
  );

  rdil_datapath #(
    .RUN_LEN     (RUN_LEN),
    .CNT_W       (CNT_W),
    .CODE_W      (CODE_W),
    .DEFECT_CODE (DEFECT_CODE),
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .FLAG_W      (FLAG_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .k2Byte     (k2Byte),
    .otherFlags (otherFlags),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .k2Match    (k2Match),
    .hitCnt     (hitCnt),
    .missCnt    (missCnt),
    .defectQ    (defectQ),
    .changeQ    (changeQ),
    .rdData     (rdData)
  );

  assign rdiDefect = defectQ;
  assign lcdReq    = defectQ;
  assign rdiChange = changeQ;

endmodule

// File: rtl/rdil_checker.sv
module rdil_checker #(
  parameter int                RUN_LEN     = 5,
  parameter int                CODE_W      = 3,
  parameter logic [CODE_W-1:0] DEFECT_CODE = 3'b110,
  parameter int                CNT_W       = $clog2(RUN_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             frameStb,
  input logic [7:0]       k2Byte,
  input logic             rdiDefect,
  input logic             lcdReq,
  input logic             rdiChange,
  input logic [CNT_W-1:0] hitCnt,
  input logic [CNT_W-1:0] missCnt
);

  // R1: reset leaves the defect and pulse low
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rdiDefect && !rdiChange));

  // R3: a declaration only follows a strobed matching frame
  p_raise_on_match_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rdiDefect) |-> $past(frameStb && (k2Byte[CODE_W-1:0] == DEFECT_CODE)));

  // R5: a clearance only follows a strobed non-matching frame
  p_drop_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rdiDefect) |-> $past(frameStb && (k2Byte[CODE_W-1:0] != DEFECT_CODE)));

  // R4: run counts never pass the run length
  p_run_saturates_r4: assert property (@(posedge clk) disable iff (rst)
    (hitCnt <= CNT_W'(RUN_LEN)) && (missCnt <= CNT_W'(RUN_LEN)));

  // R6: no strobe, no state change
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !frameStb |=> $stable(rdiDefect));

  // R8: every state change shows a pulse
  p_change_flagged_r8: assert property (@(posedge clk) disable iff (rst)
    (rdiDefect != $past(rdiDefect)) |-> rdiChange);

  // R7: a pulse always comes with a move of the request level
  p_pulse_moves_lcd_r7: assert property (@(posedge clk) disable iff (rst)
    rdiChange |-> (lcdReq != $past(lcdReq)));

endmodule

bind rdil_detector rdil_checker #(
  .RUN_LEN     (RUN_LEN),
  .CODE_W      (CODE_W),
  .DEFECT_CODE (DEFECT_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frameStb  (frameStb),
  .k2Byte    (k2Byte),
  .rdiDefect (rdiDefect),
  .lcdReq    (lcdReq),
  .rdiChange (rdiChange),
  .hitCnt    (hitCnt),
  .missCnt   (missCnt)
);

// File: tb/rdil_detector_tb.sv
module rdil_detector_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frameStb = 1'b0;
  logic [7:0]  k2Byte = 8'h00;
  logic [6:0]  otherFlags = 7'h00;
  logic        rdEn = 1'b0;
  logic [15:0] rdAddr = 16'h0000;
  logic [7:0]  rdData;
  logic        rdiDefect;
  logic        lcdReq;
  logic        rdiChange;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rdil_detector u_dut (
    .clk        (clk),
    .rst        (rst),
    .frameStb   (frameStb),
    .k2Byte     (k2Byte),
    .otherFlags (otherFlags),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .rdiDefect  (rdiDefect),
    .lcdReq     (lcdReq),
    .rdiChange  (rdiChange)
  );

  // Behavioural reference: history of the last five frame verdicts
  bit hist[$];
  bit refDef = 1'b0;
  bit refChg = 1'b0;

  always @(posedge clk) begin
    refChg = 1'b0;
    if (rst) begin
      hist.delete();
      refDef = 1'b0;
    end else if (frameStb) begin
      int hits;
      hist.push_back(k2Byte[2:0] == 3'b110);
      if (hist.size() > 5) void'(hist.pop_front());
      hits = 0;
      foreach (hist[i]) hits += int'(hist[i]);
      if (hist.size() == 5 && hits == 5 && !refDef) begin refDef = 1'b1; refChg = 1'b1; end
      if (hist.size() == 5 && hits == 0 && refDef)  begin refDef = 1'b0; refChg = 1'b1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    logic [7:0] expRd;
    if (!rst) begin
      expRd = (rdEn && rdAddr == 16'h1107) ? {refDef, otherFlags} : 8'h00;
      chk(rdiDefect == refDef, "R3/R5 defect state", rdiDefect, refDef);
      chk(lcdReq == refDef,    "R7 lcd request",     lcdReq,    refDef);
      chk(rdiChange == refChg, "R8 change pulse",    rdiChange, refChg);
      chk(rdData == expRd,     "R9/R10 read data",   rdData,    expRd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      frameStb = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] k2);
    @(negedge clk); #2;
    frameStb = 1'b1;
    k2Byte   = k2;
    @(negedge clk); #2;
    frameStb = 1'b0;
  endtask

  task automatic expectDef(input bit exp, input string tag);
    chk(rdiDefect == exp, tag, rdiDefect, exp);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    otherFlags = 7'h55;
    rdEn = 1'b1;
    rdAddr = 16'h1107;
    idle(3);
    @(negedge clk); #2; rst = 1'b0;
    @(negedge clk); #1;
    expectDef(1'b0, "R1 defect clear after reset");
    chk(rdData == 8'h55, "R1/R9 status after reset", rdData, 8'h55);

    // R4: break on fourth frame, then R2/R3 with varied upper bits
    frame(8'h06); frame(8'hFE); frame(8'h36); frame(8'h86);
    frame(8'h07);
    frame(8'h0E); frame(8'hF6); frame(8'h26); frame(8'h46);
    expectDef(1'b0, "R4 run restarted by miss");
    frame(8'h06);
    expectDef(1'b1, "R3 declared on fifth match");
    chk(rdData == 8'hD5, "R9 status with defect", rdData, 8'hD5);

    // R6: K2 changes without strobe
    k2Byte = 8'h00;
    idle(10);
    expectDef(1'b1, "R6 held without strobe");

    // R5: four misses, a match, then five misses
    frame(8'h07); frame(8'h02); frame(8'hFF); frame(8'h04);
    frame(8'hA6);
    frame(8'h00); frame(8'h01); frame(8'h03); frame(8'h05);
    expectDef(1'b1, "R5 match restarted clear run");
    frame(8'hF7);
    expectDef(1'b0, "R5 cleared on fifth miss");

    // R4: frames spaced by idle gaps still count as consecutive
    for (int i = 0; i < 5; i++) begin
      frame(8'h06);
      idle(i + 1);
    end
    expectDef(1'b1, "R4 gapped frames consecutive");

    // R9/R10: read decoding
    otherFlags = 7'h2A;
    @(negedge clk); #1;
    chk(rdData == 8'hAA, "R9 flag order", rdData, 8'hAA);
    #2; rdEn = 1'b0;
    @(negedge clk); #1;
    chk(rdData == 8'h00, "R10 read disabled", rdData, 8'h00);
    #2; rdEn = 1'b1; rdAddr = 16'h1106;
    @(negedge clk); #1;
    chk(rdData == 8'h00, "R10 wrong address", rdData, 8'h00);
    #2; rdAddr = 16'h1107;

    // R1: reset in the middle of a run
    for (int i = 0; i < 5; i++) frame(8'h01);
    expectDef(1'b0, "R5 cleared again");
    frame(8'h06); frame(8'h06); frame(8'h06);
    @(negedge clk); #2; rst = 1'b1;
    idle(2);
    @(negedge clk); #2; rst = 1'b0;
    frame(8'h06); frame(8'h06);
    expectDef(1'b0, "R1 run cleared by reset");
    frame(8'h06); frame(8'h06);
    expectDef(1'b0, "R1 four after reset");
    frame(8'h06);
    expectDef(1'b1, "R1 five after reset");

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule